// File: doc/BRIEF.md
# FM-Coded Frame Serializer

This block sends one fixed-length command frame on a single serial line. The line code marks every bit boundary with a transition. A start request latches a 2-bit device select and an 8-bit command value. The block then builds a three-byte frame: an address byte made from a fixed base plus the select, the value, and a check byte chosen so that the three bytes sum to zero modulo 256. It sends the 24 bits least significant bit first. The line coder toggles the output at the start of every bit. It adds a second toggle halfway through the bit when the bit is zero, and adds none when the bit is one. A receiver can therefore recover the clock from the transitions alone.

Bit timing is built from half-bit slots. Each slot lasts a fixed number of pulses on a clock-enable input. At the default of 200 pulses and a 1 MHz enable rate, a slot is 200 us and a bit is 400 us. After the last data bit the block issues one closing toggle. It then forces the line low after a short hold, waits out a quiet gap, and pulses a completion flag. Frame repetition, debouncing and the RF stage sit outside this block.

Top module: `fm_frame_tx`

## Requirements
- R1: After synchronous reset, `txd`, `busy` and `done` are all 0.
- R2: Every data bit begins with a toggle of `txd`. A 0 bit adds a second toggle one half-bit slot later. A 1 bit has no toggle until the next bit begins. The idle line is 0, so the first toggle of a frame drives `txd` to 1.
- R3: A half-bit slot ends on the HALF_TICKS-th cycle with `tick_en` high. Cycles with `tick_en` low do not advance the timing, and `txd` changes only on an accepting edge or on an edge where `tick_en` was high.
- R4: The frame is sent as the address byte, then the value byte, then the check byte. Each byte goes bit 0 first, so the first data bit on the line is bit 0 of the address.
- R5: The address byte is 0xA0 plus `dev_sel`, where `dev_sel[1]` has weight 2 and `dev_sel[0]` has weight 1.
- R6: The check byte makes the 8-bit sum of address, value and check byte equal zero.
- R7: One bit period after the 24th bit starts, a closing toggle is issued. CLOSE_HALVES slots later `txd` is forced to 0, and it stays 0 while `busy` is low.
- R8: GAP_HALVES slots after the forced low, `done` is high for exactly one cycle. `busy` falls on that same edge.
- R9: `busy` rises on the edge that accepts `start` and stays high until `done`. A `start` asserted while `busy` is high is ignored and produces no extra frame.
- R10: `dev_sel` and `value` are captured on the accepting edge. Changes to them during a frame do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timing enable; HALF_TICKS pulses make one half-bit slot |
| start | input | 1 | Request to send one frame, taken only while idle |
| dev_sel | input | 2 | Device select added to the address base |
| value | input | 8 | Command value byte |
| txd | output | 1 | FM-coded serial line |
| busy | output | 1 | High from acceptance until completion |
| done | output | 1 | One-cycle pulse at the end of the quiet gap |

## Verification
Frames are sent with all-zero and all-one values, with alternating and irregular bit patterns, and with every select code. The all-zero value tells a missing mid-bit toggle apart from a missing start toggle. The all-one value and the alternating pattern show that bit order and byte order are correct. One frame runs with the timing enable high on only every other cycle, which separates counting enable pulses from counting clock cycles. One frame changes its inputs and raises `start` again in mid-flight. That frame must decode to the originally latched content, and it must yield no second frame.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int          FRAME_BITS = 24;
    localparam logic [7:0]  ADDR_BASE  = 8'hA0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BIT   = 2'd1,
        ST_CLOSE = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_e;

    // packed with the first-sent byte in the low bits
    typedef struct packed {
        logic [7:0] cksum;
        logic [7:0] value;
        logic [7:0] addr;
    } frame_t;

    function automatic logic [7:0] make_addr(input logic [1:0] sel);
        return ADDR_BASE + {6'b0, sel};
    endfunction

    function automatic logic [7:0] make_cksum(input logic [7:0] a, input logic [7:0] v);
        return 8'(8'd0 - a - v);
    endfunction

endpackage

// File: rtl/fm_frame_asm.sv
module fm_frame_asm
    import fm_pkg::*;
(
    input  logic [1:0] dev_sel,
    input  logic [7:0] value,
    output frame_t     frame
);
    logic [7:0] addr_byte;

    always_comb begin
        addr_byte   = make_addr(dev_sel);
        frame.addr  = addr_byte;
        frame.value = value;
        frame.cksum = make_cksum(addr_byte, value);
    end
endmodule

// File: rtl/fm_half_timer.sv
module fm_half_timer #(
    parameter int HALF_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick_en,
    output logic half_end
);
    generate
        if (HALF_TICKS <= 1) begin : g_direct
            assign half_end = run && tick_en;
        end else begin : g_count
            localparam int CW = $clog2(HALF_TICKS);
            localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt <= '0;
                end else if (run && tick_en) begin
                    if (cnt == LAST) cnt <= '0;
                    else             cnt <= cnt + 1'b1;
                end
            end

            assign half_end = run && tick_en && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/fm_shift_reg.sv
module fm_shift_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         head
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (load)  sr <= load_data;
        else if (shift) sr <= {1'b0, sr[W-1:1]};
    end

    assign head = sr[0];
endmodule

// File: rtl/fm_frame_tx.sv
module fm_frame_tx
    import fm_pkg::*;
#(
    parameter int HALF_TICKS   = 200,
    parameter int CLOSE_HALVES = 2,
    parameter int GAP_HALVES   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       start,
    input  logic [1:0] dev_sel,
    input  logic [7:0] value,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int HMAX = (CLOSE_HALVES > GAP_HALVES) ? CLOSE_HALVES : GAP_HALVES;
    localparam int HW   = (HMAX > 1) ? $clog2(HMAX) : 1;
    localparam int BW   = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
    localparam logic [HW-1:0] CLOSE_LAST = HW'(CLOSE_HALVES - 1);
    localparam logic [HW-1:0] GAP_LAST   = HW'(GAP_HALVES - 1);

    tx_state_e     state;
    frame_t        frame_new;
    logic          accept;
    logic          half_end;
    logic          cur_bit;
    logic          shift_en;
    logic          second_half;
    logic [BW-1:0] bit_idx;
    logic [HW-1:0] slot_cnt;

    assign accept   = (state == ST_IDLE) && start;
    assign shift_en = (state == ST_BIT) && half_end && second_half;

    fm_frame_asm u_asm (
        .dev_sel (dev_sel),
        .value   (value),
        .frame   (frame_new)
    );

    fm_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .run      (state != ST_IDLE),
        .tick_en  (tick_en),
        .half_end (half_end)
    );

    fm_shift_reg #(.W(FRAME_BITS)) u_sr (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (frame_new),
        .shift     (shift_en),
        .head      (cur_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            txd         <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            second_half <= 1'b0;
            bit_idx     <= '0;
            slot_cnt    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_BIT;
                        txd         <= ~txd;
                        busy        <= 1'b1;
                        second_half <= 1'b0;
                        bit_idx     <= '0;
                    end
                end
                ST_BIT: begin
                    if (half_end) begin
                        if (!second_half) begin
                            if (!cur_bit) txd <= ~txd;
                            second_half <= 1'b1;
                        end else begin
                            second_half <= 1'b0;
                            txd         <= ~txd;
                            if (bit_idx == LAST_BIT) begin
                                state    <= ST_CLOSE;
                                slot_cnt <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_CLOSE: begin
                    if (half_end) begin
                        if (slot_cnt == CLOSE_LAST) begin
                            txd      <= 1'b0;
                            state    <= ST_GAP;
                            slot_cnt <= '0;
                        end else begin
                            slot_cnt <= slot_cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (half_end) begin
                        if (slot_cnt == GAP_LAST) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            slot_cnt <= slot_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fm_frame_tx_chk.sv
module fm_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic start,
    input logic txd,
    input logic busy,
    input logic done
);
    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !txd);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_busy_rise_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    p_line_paced_r3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(txd) && !$rose(busy)) |-> $past(tick_en));
endmodule

bind fm_frame_tx fm_frame_tx_chk u_chk (.*);

// File: tb/fm_frame_tx_tb.sv
module fm_frame_tx_tb;
    localparam int HT    = 4;
    localparam int CLOSE = 2;
    localparam int GAP   = 4;

    typedef struct {
        logic [23:0] bits;
        int          h;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       div2 = 1'b0;
    logic       start = 1'b0;
    logic [1:0] dev_sel = 2'd0;
    logic [7:0] value = 8'd0;
    logic       txd, busy, done;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   frames_seen = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_en <= div2 ? ~tick_en : 1'b1;

    fm_frame_tx #(.HALF_TICKS(HT), .CLOSE_HALVES(CLOSE), .GAP_HALVES(GAP)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
        .dev_sel(dev_sel), .value(value), .txd(txd), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // driver: push expected frame, pulse start, optionally disturb mid-frame
    task automatic send(input logic [1:0] s, input logic [7:0] v, input bit slow, input bit disturb);
        exp_t e;
        logic [7:0] a, c;
        a = 8'hA0 + {6'b0, s};
        c = 8'(8'd0 - a - v);
        e.bits = {c, v, a};
        e.h = slow ? 2 * HT : HT;
        exp_q.push_back(e);
        @(negedge clk);
        div2 = slow;
        repeat (3) @(negedge clk);
        dev_sel = s;
        value = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (30) @(negedge clk);
            dev_sel = ~s;
            value = ~v;
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (!done);
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_edge(inout logic prev, output int t);
        do @(negedge clk); while (txd == prev);
        prev = txd;
        t = cyc;
    endtask

    // monitor: decode line, compare against scoreboard
    initial begin
        exp_t        e;
        logic        prev;
        logic [23:0] got;
        int          ts, t1, t2, d;
        forever begin
            do @(negedge clk); while (!busy);
            chk(txd == 1'b1, "R2 first toggle", txd, 1);
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected frame", 1, 0);
                e.bits = '0;
                e.h = HT;
            end else begin
                e = exp_q.pop_front();
            end
            prev = txd;
            ts = cyc;
            for (int i = 0; i < 24; i++) begin
                wait_edge(prev, t1);
                d = t1 - ts;
                if (2 * d < 3 * e.h) begin
                    got[i] = 1'b0;
                    if (i != 0) chk(d == e.h, "R3 zero half", d, e.h);
                    wait_edge(prev, t2);
                    chk(t2 - t1 == e.h, "R2 zero second half", t2 - t1, e.h);
                    ts = t2;
                end else begin
                    got[i] = 1'b1;
                    if (i != 0) chk(d == 2 * e.h, "R3 one bit", d, 2 * e.h);
                    ts = t1;
                end
            end
            chk(got[7:0] == e.bits[7:0], "R5 address byte", got[7:0], e.bits[7:0]);
            chk(got == e.bits, "R4 R10 frame content", got, e.bits);
            chk(8'(got[7:0] + got[15:8] + got[23:16]) == 8'd0, "R6 zero sum",
                8'(got[7:0] + got[15:8] + got[23:16]), 0);
            // ts is the closing toggle
            while (!done) begin
                @(negedge clk);
                if (!done && (cyc - ts) > (CLOSE + GAP + 2) * e.h) begin
                    chk(0, "R8 done missing", 0, 1);
                    break;
                end
                if (cyc - ts >= CLOSE * e.h && busy)
                    if (txd) chk(0, "R7 forced low", txd, 0);
            end
            chk(cyc - ts == (CLOSE + GAP) * e.h, "R7 R8 close timing", cyc - ts, (CLOSE + GAP) * e.h);
            chk(txd == 1'b0, "R7 line low at done", txd, 0);
            chk(busy == 1'b0, "R8 busy falls with done", busy, 0);
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", done, 0);
            chk(txd == 1'b0, "R7 idle low", txd, 0);
            frames_seen++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b0, "R1 txd reset", txd, 0);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(done == 1'b0, "R1 done reset", done, 0);

        send(2'd0, 8'h00, 0, 0);   // R2: all zeros
        send(2'd3, 8'hFF, 0, 0);   // R4 R5: all ones, top select
        send(2'd1, 8'h55, 0, 0);   // R4: alternating
        send(2'd2, 8'hA3, 1, 0);   // R3: enable every other cycle
        send(2'd2, 8'h80, 0, 1);   // R9 R10: restart attempt and input change
        send(2'd3, 8'h01, 0, 0);

        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R9 no extra frame busy", busy, 0);
        chk(frames_seen == 6, "R9 frame count", frames_seen, 6);
        chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule